// File: doc/BRIEF.md
# Push-Button Interrupt Register Slave

This block connects a single push-button line to a Wishbone bus. The button signal is not synchronous to the bus clock, so it first passes through a chain of flip-flops that brings it into the clock domain. The synchronized level can be read as a 16-bit read-only register. The button state is in bit 0, and every other bit reads as zero.

An edge detector watches the synchronized level. When the button goes from released to pressed, it produces a one-clock interrupt pulse. This pulse goes to a downstream interrupt aggregator and not to a processor. Masking and pending state are kept by that aggregator, so this block only marks the press event.

The bus side answers every access with a one-cycle acknowledge. A read returns the button level during the acknowledge cycle. A write gets the same acknowledge but changes nothing, because the block holds no writable state.

Top module: `pushbutton_irq_slave`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `wbAck`, `irqPulse` and `wbDatOut` are all zero.
- R2: When `wbCyc` and `wbStb` are both high at a clock edge and `wbAck` is low, `wbAck` goes high after that edge for exactly one cycle. `wbAck` is never high in two consecutive cycles, so a held request is acknowledged on alternate cycles.
- R3: `wbAck` stays low after any edge at which `wbCyc` and `wbStb` were not both high.
- R4: In the acknowledge cycle of a read (`wbWe` low), bit 0 of `wbDatOut` equals the synchronized button level, with 1 meaning pressed.
- R5: Bits 15:1 of `wbDatOut` are always zero, and all of `wbDatOut` is zero whenever `wbAck` is low.
- R6: A write (`wbWe` high) is acknowledged like a read, with `wbDatOut` zero in its acknowledge cycle. It has no effect on later reads or on the interrupt output.
- R7: A 0-to-1 change of `btnIn` produces `irqPulse` high for exactly one cycle. The pulse appears after the (SYNC_STAGES+1)-th clock edge following the change (the third edge with the default of 2).
- R8: Releasing the button, or holding it pressed, produces no further `irqPulse`.
- R9: The level after reset is taken as released. A button already held during reset gives one interrupt pulse after reset is released.
- R10: Two separate presses, each preceded by a release long enough to pass the synchronizer, give two separate pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| btnIn | input | 1 | Asynchronous button line, 1 = pressed |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Strobe for this slave |
| wbWe | input | 1 | 1 = write, 0 = read |
| wbDatOut | output | 16 | Read data |
| wbAck | output | 1 | Transfer acknowledge |
| irqPulse | output | 1 | One-cycle press interrupt |

## Verification
The bench measures the interrupt latency edge by edge. A design with a missing or extra synchronizer stage would move the pulse by a cycle, and a combinational detector would raise it one edge early.

It holds the button pressed and then releases it. An edge detector built as a level or toggle detector would pulse more than once or on release. It also asserts the button during reset, which catches a detector whose history is not cleared to released.

On the bus side, the bench holds a request for several cycles to catch an acknowledge that sticks high. It sends only one of `wbCyc` and `wbStb` to catch decoding that uses either signal alone. It issues writes and then reads to show that nothing was latched and that no stale data leaks onto the read lines.

// File: rtl/pbirq_pkg.sv
package pbirq_pkg;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic loadRead;
  } busStrobe_t;
endpackage

// File: rtl/pbirq_ctrl.sv
module pbirq_ctrl
  import pbirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wbCyc,
  input  logic       wbStb,
  input  logic       wbWe,
  output busStrobe_t strobes,
  output logic       wbAck
);
  logic request;
  logic ackReg;

  assign request = wbCyc & wbStb & ~ackReg;

  always_ff @(posedge clk) begin
    if (rst) ackReg <= 1'b0;
    else     ackReg <= request;
  end

  always_comb begin
    strobes          = '0;
    strobes.loadRead = request & ~wbWe;
  end

  assign wbAck = ackReg;
endmodule

// File: rtl/pbirq_datapath.sv
module pbirq_datapath
  import pbirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH       = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btnIn,
  input  busStrobe_t       strobes,
  output logic [WIDTH-1:0] rdData,
  output logic             btnLevel,
  output logic             irqPulse
);
  localparam int PAD_W = WIDTH - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   levelPrev;
  logic                   irqReg;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= btnIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], btnIn};
      end
    end
  endgenerate

  assign btnLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      levelPrev <= 1'b0;
      irqReg    <= 1'b0;
    end else begin
      levelPrev <= btnLevel;
      irqReg    <= btnLevel & ~levelPrev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdData <= '0;
    else if (strobes.loadRead) rdData <= {{PAD_W{1'b0}}, btnLevel};
    else                       rdData <= '0;
  end

  assign irqPulse = irqReg;
endmodule

// File: rtl/pushbutton_irq_slave.sv
module pushbutton_irq_slave
  import pbirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btnIn,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  output logic [DATA_W-1:0] wbDatOut,
  output logic              wbAck,
  output logic              irqPulse
);
  busStrobe_t strobes;
  logic       btnLevel;

  pbirq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wbCyc   (wbCyc),
    .wbStb   (wbStb),
    .wbWe    (wbWe),
    .strobes (strobes),
    .wbAck   (wbAck)
  );

  pbirq_datapath #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .btnIn    (btnIn),
    .strobes  (strobes),
    .rdData   (wbDatOut),
    .btnLevel (btnLevel),
    .irqPulse (irqPulse)
  );
endmodule

// File: rtl/pbirq_checker.sv
module pbirq_checker
  import pbirq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wbCyc,
  input logic              wbStb,
  input logic              wbWe,
  input logic [DATA_W-1:0] wbDatOut,
  input logic              wbAck,
  input logic              irqPulse,
  input logic              btnLevel
);
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);

  assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    wbAck |-> $past(wbCyc && wbStb));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    wbDatOut[DATA_W-1:1] == '0);

  assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !wbAck |-> (wbDatOut == '0));

  assert_write_data_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (wbAck && $past(wbWe)) |-> (wbDatOut == '0));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);

  assert_irq_on_press_R8: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> ($past(btnLevel) && !$past(btnLevel, 2)));
endmodule

bind pushbutton_irq_slave pbirq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .wbCyc    (wbCyc),
  .wbStb    (wbStb),
  .wbWe     (wbWe),
  .wbDatOut (wbDatOut),
  .wbAck    (wbAck),
  .irqPulse (irqPulse),
  .btnLevel (btnLevel)
);

// File: tb/tb_pushbutton_irq_slave.sv
`timescale 1ns/1ps
module tb_pushbutton_irq_slave;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btnIn = 1'b0;
  logic        wbCyc = 1'b0;
  logic        wbStb = 1'b0;
  logic        wbWe = 1'b0;
  logic [15:0] wbDatOut;
  logic        wbAck;
  logic        irqPulse;

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;

  always #2.5 clk = ~clk;

  pushbutton_irq_slave dut (
    .clk(clk), .rst(rst), .btnIn(btnIn), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbWe(wbWe), .wbDatOut(wbDatOut), .wbAck(wbAck), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busAccess(input logic we, input string req, input logic [15:0] expData);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we;
    tick(1);
    check(req, "ack", wbAck, 1);
    check(req, "data", wbDatOut, expData);
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    tick(1);
    check("R5", "ack after", wbAck, 0);
    check("R5", "data idle", wbDatOut, 0);
  endtask

  task automatic testReset();
    rst = 1'b1; btnIn = 1'b0;
    tick(3);
    check("R1", "ack in reset", wbAck, 0);
    check("R1", "irq in reset", irqPulse, 0);
    check("R1", "data in reset", wbDatOut, 0);
    rst = 1'b0;
    tick(1);
    check("R1", "irq after reset", irqPulse, 0);
    check("R1", "data after reset", wbDatOut, 0);
  endtask

  task automatic testReads();
    btnIn = 1'b0; tick(5);
    busAccess(1'b0, "R4", 16'h0000);
    btnIn = 1'b1; tick(5);
    busAccess(1'b0, "R4", 16'h0001);
    btnIn = 1'b0; tick(5);
    busAccess(1'b0, "R4", 16'h0000);
  endtask

  task automatic testHeldRequest();
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = 1'b0;
    tick(1); check("R2", "held ack 1", wbAck, 1);
    tick(1); check("R2", "held ack 2", wbAck, 0);
    tick(1); check("R2", "held ack 3", wbAck, 1);
    wbCyc = 1'b0; wbStb = 1'b0;
    tick(1); check("R2", "held ack end", wbAck, 0);
  endtask

  task automatic testPartialRequest();
    wbCyc = 1'b1; wbStb = 1'b0;
    tick(2); check("R3", "cyc only", wbAck, 0);
    wbCyc = 1'b0; wbStb = 1'b1;
    tick(2); check("R3", "stb only", wbAck, 0);
    check("R5", "no ack data", wbDatOut, 0);
    wbStb = 1'b0; tick(1);
  endtask

  task automatic testWrite();
    btnIn = 1'b1; tick(5);
    busAccess(1'b1, "R6", 16'h0000);
    check("R6", "no irq from write", irqPulse, 0);
    busAccess(1'b0, "R6", 16'h0001);
    btnIn = 1'b0; tick(5);
    busAccess(1'b1, "R6", 16'h0000);
    busAccess(1'b0, "R6", 16'h0000);
  endtask

  task automatic testPressLatency();
    btnIn = 1'b0; tick(6);
    btnIn = 1'b1;
    for (int e = 1; e <= LAT + 2; e++) begin
      tick(1);
      check("R7", $sformatf("irq after edge %0d", e), irqPulse, (e == LAT) ? 1 : 0);
    end
  endtask

  task automatic testHoldRelease();
    int pulses = 0;
    btnIn = 1'b0; tick(6);
    btnIn = 1'b1;
    for (int i = 0; i < 12; i++) begin tick(1); if (irqPulse) pulses++; end
    check("R7", "one pulse per press", pulses, 1);
    pulses = 0;
    btnIn = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(1); if (irqPulse) pulses++; end
    check("R8", "no pulse on release/hold", pulses, 0);
  endtask

  task automatic testTwoPresses();
    int pulses = 0;
    btnIn = 1'b0; tick(6);
    for (int p = 0; p < 2; p++) begin
      btnIn = 1'b1;
      for (int i = 0; i < 6; i++) begin tick(1); if (irqPulse) pulses++; end
      btnIn = 1'b0;
      for (int i = 0; i < 6; i++) begin tick(1); if (irqPulse) pulses++; end
    end
    check("R10", "two presses two pulses", pulses, 2);
  endtask

  task automatic testHeldThroughReset();
    int pulses = 0;
    rst = 1'b1; btnIn = 1'b1;
    tick(4);
    check("R9", "no irq in reset", irqPulse, 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin tick(1); if (irqPulse) pulses++; end
    check("R9", "pulse after reset", pulses, 1);
    btnIn = 1'b0; tick(5);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testReads();
    testHeldRequest();
    testPartialRequest();
    testWrite();
    testPressLatency();
    testHoldRelease();
    testTwoPresses();
    testHeldThroughReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule